// File: doc/BRIEF.md
# Full-Bridge PWM Modulator

This block drives the four switches of a single-phase full-bridge voltage-source inverter. An internal up/down counter forms a symmetric triangular carrier. Each leg turns the carrier position into an on/off command by comparing it with a signed reference sample. A blanking stage then splits that command into an upper and a lower gate, so the two switches of a leg are never on together.

Two modulation schemes are available. In the three-level scheme, leg A compares the reference and leg B compares its negation. In the two-level scheme, one comparison drives the diagonal pairs: the leg A upper switch turns on with the leg B lower switch. Reference and mode are taken only at the carrier peak, and the block emits a strobe in that cycle. An upstream source of sine samples can use the strobe to keep the reference in step with the carrier, so that the carrier-to-reference frequency ratio stays an integer.

Top module: `pwm_fullbridge_mod`

## Requirements
- R1: The carrier count rises by one per cycle from 0 to the period value, then falls back to 0. `peak_o` is high for exactly the one cycle in which the count equals the period while rising, so peaks are 2*period cycles apart.
- R2: `ref_i` and `mode_i` are sampled only at the clock edge that ends a peak cycle. Changes at other times have no effect on the gates until the next peak.
- R3: With `mode_i` low (three-level), leg A's command is high when reference > 2*count - period. Leg B's command is high when -reference > 2*count - period.
- R4: With `mode_i` high (two-level), leg A's command is as in R3 and leg B's command is its complement. Once settled, `gate_b_hi_o` equals `gate_a_lo_o` and `gate_b_lo_o` equals `gate_a_hi_o` on every cycle.
- R5: The upper and lower gate of a leg are never high in the same cycle.
- R6: When a leg's command changes, the conducting gate drops one cycle after the change is registered. The other gate rises only after both gates have been off for max(`deadtime_i`, 1) cycles with the command held steady.
- R7: A command pulse that lasts no more than `deadtime_i` cycles never turns on the incoming switch.
- R8: Suppose the reference is above the period (overmodulation) in three-level mode. Then leg A stays with its upper gate on and leg B with its lower gate on for the whole carrier cycle.
- R9: A synchronous active-high reset forces all four gates and `peak_o` low and restarts the carrier at 0, rising.
- R10: A period value of 0 is handled as 1, which gives peaks every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | REF_W | Signed reference sample, two's complement |
| period_i | input | CNT_W | Carrier peak count |
| deadtime_i | input | DT_W | Blanking length in cycles |
| mode_i | input | 1 | 0 = three-level, 1 = two-level |
| gate_a_hi_o | output | 1 | Leg A upper switch |
| gate_a_lo_o | output | 1 | Leg A lower switch |
| gate_b_hi_o | output | 1 | Leg B upper switch |
| gate_b_lo_o | output | 1 | Leg B lower switch |
| peak_o | output | 1 | Carrier-peak strobe for reference updates |

## Verification
The bound checker watches, on every cycle, the mutual exclusion within each leg, the break-before-make order, the single-cycle width of the peak strobe and the gate state after reset. Several properties depend on numeric stimulus and can only be shown by the bench scenarios. These are the comparison rules of each mode, the exact blanking length, the swallowing of short pulses, overmodulation saturation, and the fact that references are taken only at peaks. The bench checks them with a cycle-level reference model and with windowed counts of gate activity.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int LEGS = 2;

    typedef enum logic {
        MODE_THREE_LEVEL = 1'b0,
        MODE_TWO_LEVEL   = 1'b1
    } pwm_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_gate_t;

    typedef struct packed {
        logic leg_b;
        logic leg_a;
    } leg_cmd_t;

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             peak_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             rising_q;
    logic             at_top;

    assign at_top = (cnt_q >= period_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q    <= '0;
            rising_q <= 1'b1;
        end else if (rising_q) begin
            if (at_top) begin
                rising_q <= 1'b0;
                cnt_q    <= cnt_q - 1'b1;
            end else begin
                cnt_q    <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == '0) begin
                rising_q <= 1'b1;
                cnt_q    <= cnt_q + 1'b1;
            end else begin
                cnt_q    <= cnt_q - 1'b1;
            end
        end
    end

    assign count_o = cnt_q;
    assign peak_o  = rising_q && at_top;

endmodule

// File: rtl/pwm_leg_cmp.sv
module pwm_leg_cmp
    import pwm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int REF_W = 12
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    peak_i,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic                    mode_i,
    input  logic [CNT_W-1:0]        count_i,
    input  logic [CNT_W-1:0]        period_i,
    output leg_cmd_t                cmd_o
);

    localparam int BASE_W = (REF_W > CNT_W + 1) ? REF_W : CNT_W + 1;
    localparam int CW     = BASE_W + 2;

    logic signed [REF_W-1:0] ref_q;
    pwm_mode_e               mode_q;
    leg_cmd_t                cmd_q;
    leg_cmd_t                cmd_next;
    logic signed [CW-1:0]    ref_x;
    logic signed [CW-1:0]    neg_x;
    logic signed [CW-1:0]    car_x;

    // Signed carrier spanning -period .. +period in steps of two.
    assign ref_x = CW'(ref_q);
    assign neg_x = -ref_x;
    assign car_x = signed'(CW'({count_i, 1'b0})) - signed'(CW'(period_i));

    always_comb begin
        cmd_next.leg_a = (ref_x > car_x);
        if (mode_q == MODE_TWO_LEVEL) begin
            cmd_next.leg_b = !cmd_next.leg_a;
        end else begin
            cmd_next.leg_b = (neg_x > car_x);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ref_q  <= '0;
            mode_q <= MODE_THREE_LEVEL;
            cmd_q  <= '0;
        end else begin
            cmd_q <= cmd_next;
            if (peak_i) begin
                ref_q  <= ref_i;
                mode_q <= pwm_mode_e'(mode_i);
            end
        end
    end

    assign cmd_o = cmd_q;

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import pwm_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            cmd_i,
    input  logic [DT_W-1:0] dt_i,
    output leg_gate_t       gate_o
);

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    logic            hi_q;
    logic            lo_q;
    logic            cmd_q;
    logic [DT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
            cmd_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            cmd_q <= cmd_i;
            if (hi_q) begin
                if (!cmd_i) begin
                    hi_q  <= 1'b0;
                    cnt_q <= ONE;
                end
            end else if (lo_q) begin
                if (cmd_i) begin
                    lo_q  <= 1'b0;
                    cnt_q <= ONE;
                end
            end else if (cmd_i != cmd_q) begin
                cnt_q <= ONE;
            end else if (cnt_q >= dt_i) begin
                hi_q <= cmd_i;
                lo_q <= !cmd_i;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign gate_o.hi = hi_q;
    assign gate_o.lo = lo_q;

endmodule

// File: rtl/pwm_fullbridge_mod.sv
module pwm_fullbridge_mod
    import pwm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int REF_W = 12,
    parameter int DT_W  = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [CNT_W-1:0]        period_i,
    input  logic [DT_W-1:0]         deadtime_i,
    input  logic                    mode_i,
    output logic                    gate_a_hi_o,
    output logic                    gate_a_lo_o,
    output logic                    gate_b_hi_o,
    output logic                    gate_b_lo_o,
    output logic                    peak_o
);

    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] count;
    logic             peak;
    leg_cmd_t         cmd;
    logic [LEGS-1:0]  cmd_bits;
    leg_gate_t        gates [LEGS];

    assign per_eff  = (period_i == '0) ? CNT_W'(1) : period_i;
    assign cmd_bits = {cmd.leg_b, cmd.leg_a};

    pwm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .period_i (per_eff),
        .count_o  (count),
        .peak_o   (peak)
    );

    pwm_leg_cmp #(.CNT_W(CNT_W), .REF_W(REF_W)) u_cmp (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .peak_i   (peak),
        .ref_i    (ref_i),
        .mode_i   (mode_i),
        .count_i  (count),
        .period_i (per_eff),
        .cmd_o    (cmd)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        pwm_deadband #(.DT_W(DT_W)) u_db (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .cmd_i  (cmd_bits[g]),
            .dt_i   (deadtime_i),
            .gate_o (gates[g])
        );
    end

    assign gate_a_hi_o = gates[0].hi;
    assign gate_a_lo_o = gates[0].lo;
    assign gate_b_hi_o = gates[1].hi;
    assign gate_b_lo_o = gates[1].lo;
    assign peak_o      = peak;

endmodule

// File: rtl/pwm_fullbridge_chk.sv
module pwm_fullbridge_chk (
    input logic clk_i,
    input logic rst_i,
    input logic gate_a_hi_o,
    input logic gate_a_lo_o,
    input logic gate_b_hi_o,
    input logic gate_b_lo_o,
    input logic peak_o
);

    a_r5_leg_a_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(gate_a_hi_o && gate_a_lo_o));

    a_r5_leg_b_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(gate_b_hi_o && gate_b_lo_o));

    a_r9_reset_gates_off: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !(gate_a_hi_o || gate_a_lo_o || gate_b_hi_o || gate_b_lo_o || peak_o));

    a_r1_peak_single: assert property (@(posedge clk_i) disable iff (rst_i)
        peak_o |=> !peak_o);

    a_r6_break_first_a: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(gate_a_lo_o) || $rose(gate_a_hi_o)) |-> $past(!gate_a_hi_o && !gate_a_lo_o));

    a_r6_break_first_b: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(gate_b_lo_o) || $rose(gate_b_hi_o)) |-> $past(!gate_b_hi_o && !gate_b_lo_o));

endmodule

bind pwm_fullbridge_mod pwm_fullbridge_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .gate_a_hi_o (gate_a_hi_o),
    .gate_a_lo_o (gate_a_lo_o),
    .gate_b_hi_o (gate_b_hi_o),
    .gate_b_lo_o (gate_b_lo_o),
    .peak_o      (peak_o)
);

// File: tb/sim_pwm_fullbridge_mod.sv
`timescale 1ns/1ps
module sim_pwm_fullbridge_mod;

    localparam int CNT_W = 10;
    localparam int REF_W = 12;
    localparam int DT_W  = 6;
    localparam int P     = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [REF_W-1:0] ref_in = '0;
    logic [CNT_W-1:0] period = CNT_W'(P);
    logic [DT_W-1:0]  dt = DT_W'(3);
    logic mode = 1'b0;
    logic ah, al, bh, bl, pk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_fullbridge_mod #(.CNT_W(CNT_W), .REF_W(REF_W), .DT_W(DT_W)) u0 (
        .clk_i(clk), .rst_i(rst), .ref_i(ref_in), .period_i(period),
        .deadtime_i(dt), .mode_i(mode),
        .gate_a_hi_o(ah), .gate_a_lo_o(al), .gate_b_hi_o(bh), .gate_b_lo_o(bl),
        .peak_o(pk)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of the requirements; pushes one expected item per cycle.
    typedef struct packed { logic ah; logic al; logic bh; logic bl; logic pk; } exp_t;
    exp_t sb_q[$];
    int m_cnt; bit m_rise; int m_ref; bit m_mode;
    bit m_cmd[2]; bit m_hi[2]; bit m_lo[2]; bit m_cq[2]; int m_cn[2];

    always @(posedge clk) begin
        int peff; int car; bit na; bit nb; exp_t e;
        peff = (period == 0) ? 1 : int'(period);
        if (rst) begin
            m_cnt = 0; m_rise = 1; m_ref = 0; m_mode = 0;
            for (int l = 0; l < 2; l++) begin
                m_cmd[l] = 0; m_hi[l] = 0; m_lo[l] = 0; m_cq[l] = 0; m_cn[l] = 0;
            end
        end else begin
            car = 2 * m_cnt - peff;
            na = (m_ref > car);
            nb = m_mode ? !na : ((-m_ref) > car);
            for (int l = 0; l < 2; l++) begin
                if (m_hi[l]) begin
                    if (!m_cmd[l]) begin m_hi[l] = 0; m_cn[l] = 1; end
                end else if (m_lo[l]) begin
                    if (m_cmd[l]) begin m_lo[l] = 0; m_cn[l] = 1; end
                end else if (m_cmd[l] != m_cq[l]) begin
                    m_cn[l] = 1;
                end else if (m_cn[l] >= int'(dt)) begin
                    m_hi[l] = m_cmd[l]; m_lo[l] = !m_cmd[l];
                end else begin
                    m_cn[l]++;
                end
                m_cq[l] = m_cmd[l];
            end
            if (m_rise && m_cnt >= peff) begin
                m_ref = int'(ref_in); m_mode = mode;
            end
            if (m_rise) begin
                if (m_cnt >= peff) begin m_rise = 0; m_cnt--; end else m_cnt++;
            end else begin
                if (m_cnt == 0) begin m_rise = 1; m_cnt++; end else m_cnt--;
            end
            m_cmd[0] = na; m_cmd[1] = nb;
        end
        e.ah = m_hi[0]; e.al = m_lo[0]; e.bh = m_hi[1]; e.bl = m_lo[1];
        e.pk = m_rise && (m_cnt >= peff);
        sb_q.push_back(e);
    end

    // Monitor: pops expected items and compares away from the active edge.
    always @(negedge clk) begin
        exp_t e; exp_t a;
        if (!done && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            a = {ah, al, bh, bl, pk};
            chk(a == e, "R1 R3 R4 R6 scoreboard {ah,al,bh,bl,pk}", int'(a), int'(e));
            chk(!(ah && al) && !(bh && bl), "R5 leg exclusive", int'(a), int'(e));
        end
    end

    task automatic wait_peak();
        int guard = 0;
        @(negedge clk);
        while (!pk && guard < 5000) begin @(negedge clk); guard++; end
    endtask

    task automatic restart(input int per);
        @(negedge clk); rst = 1; period = CNT_W'(per);
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        int n; int c1; int c2; int c3;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({ah, al, bh, bl, pk} == 5'b0, "R9 outputs in reset", int'({ah, al, bh, bl, pk}), 0);
        rst = 0;

        // R1: peak spacing
        wait_peak(); wait_peak();
        n = 0;
        @(negedge clk); n++;
        while (!pk && n < 1000) begin @(negedge clk); n++; end
        chk(n == 2 * P, "R1 peak spacing", n, 2 * P);

        // R3: three-level, zero reference -> legs identical
        ref_in = 0; mode = 0;
        wait_peak(); wait_peak();
        c1 = 0;
        for (int i = 0; i < 2 * P; i++) begin @(negedge clk); if (bh != ah) c1++; end
        chk(c1 == 0, "R3 zero ref legs match", c1, 0);

        // R3: positive reference -> leg A upper on longer than leg B upper
        @(negedge clk); ref_in = 10;
        wait_peak(); wait_peak();
        c1 = 0; c2 = 0;
        for (int i = 0; i < 2 * P; i++) begin @(negedge clk); c1 += int'(ah); c2 += int'(bh); end
        chk(c1 > c2, "R3 leg A duty exceeds leg B", c1, c2);

        // R2: reference change after a peak waits for next peak
        @(negedge clk); ref_in = 0;
        wait_peak(); wait_peak();
        @(negedge clk); ref_in = P + 5;
        c1 = 0;
        while (!pk) begin @(negedge clk); c1 += int'(al); end
        chk(c1 > 0, "R2 old ref held until peak", c1, 1);

        // R8: overmodulation saturates
        wait_peak(); wait_peak();
        c1 = 0; c2 = 0; c3 = 0;
        for (int i = 0; i < 2 * P; i++) begin
            @(negedge clk); c1 += int'(ah); c2 += int'(al); c3 += int'(bl);
        end
        chk(c1 == 2 * P, "R8 leg A upper held", c1, 2 * P);
        chk(c2 == 0, "R8 leg A lower off", c2, 0);
        chk(c3 == 2 * P, "R8 leg B lower held", c3, 2 * P);

        // R6: blanking length equals deadtime
        @(negedge clk); ref_in = 0; dt = 3;
        wait_peak(); wait_peak();
        n = 0;
        while (!ah && n < 1000) begin @(negedge clk); n++; end
        while (ah && n < 2000) begin @(negedge clk); n++; end
        c1 = 0;
        while (!al && c1 < 100) begin @(negedge clk); c1++; end
        chk(c1 == 3, "R6 blanking cycles dt=3", c1, 3);

        // R7: pulses no longer than deadtime produce no turn-on
        @(negedge clk); ref_in = P - 1; dt = 2;
        wait_peak(); wait_peak();
        c1 = 0; c2 = 0;
        for (int i = 0; i < 4 * P; i++) begin @(negedge clk); c1 += int'(al); c2 += int'(bh); end
        chk(c1 == 0, "R7 leg A lower never on", c1, 0);
        chk(c2 == 0, "R7 leg B upper never on", c2, 0);

        // R4: two-level diagonal pairing
        @(negedge clk); ref_in = 6; mode = 1; dt = 2;
        wait_peak(); wait_peak(); wait_peak();
        c1 = 0;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk); if (bh != al || bl != ah) c1++;
        end
        chk(c1 == 0, "R4 diagonal pairs match", c1, 0);

        // R10: zero period behaves as one
        restart(0);
        wait_peak();
        n = 0;
        @(negedge clk); n++;
        while (!pk && n < 100) begin @(negedge clk); n++; end
        chk(n == 2, "R10 zero period spacing", n, 2);

        // R9: reset mid-run clears gates
        repeat (20) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk({ah, al, bh, bl, pk} == 5'b0, "R9 reset mid-run", int'({ah, al, bh, bl, pk}), 0);
        rst = 0;
        repeat (10) @(negedge clk);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule